// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock

This unit decides, for an in-order five-stage integer pipeline, where each of the two ALU operands comes from. There are three possible sources: the register file, the result held in the EX/MEM pipeline register, or the result held in the MEM/WB pipeline register. It works one stage early. While an instruction sits in decode, the unit compares the source register numbers that instruction really uses against the destination of the instruction now in execute and the one now in memory. It registers the outcome, so the select lines are ready at the start of the cycle in which that instruction executes.

The unit also finds the one case that bypassing cannot cover. That case is an instruction that reads a register loaded by the instruction directly ahead of it. In that cycle the unit holds the program counter and the IF/ID register and turns the entry into ID/EX into a bubble. A store whose only dependence on that load is through its data operand is not stalled. Instead it receives a late-select flag in its memory stage, so the loaded value can be steered into the store data. The register file writes before it reads within a cycle, so a writer three stages ahead of a reader needs no path through this unit.

Top module: `fwd_hazard_unit`

## Requirements
- R1: While reset is low and on the first cycle after it, `fwd_sel_a` and `fwd_sel_b` are 2'b00 and `st_data_fwd` is 0.
- R2: If a used decode source equals a nonzero `ex_rd` with `ex_wen` high and `ex_is_load` low, that operand's select is 2'b10 (EX/MEM) in the following cycle.
- R3: If a used decode source equals a nonzero `mem_rd` with `mem_wen` high, and no execute-stage match exists, that operand's select is 2'b01 (MEM/WB) in the following cycle.
- R4: When both the execute-stage and the memory-stage writer match the same source, the select in the following cycle is 2'b10.
- R5: A destination of register 0, or a writer with its write enable low, never produces a select other than 2'b00 and never causes a stall.
- R6: A source whose use flag is low is ignored. Its select stays 2'b00 and it cannot cause a stall.
- R7: If `ex_is_load` is high and a used rs1 matches `ex_rd`, or a used rs2 of a non-store matches it, then `pc_hold`, `ifid_hold` and `idex_bubble` are high in that same cycle. Both selects are 2'b00 in the following cycle.
- R8: After a stall, the held instruction matches the load in the memory stage and gets select 2'b01 in the next cycle. A single dependence therefore stalls for exactly one cycle.
- R9: A store (`id_is_store` high) whose rs2 alone matches a load in execute does not stall. Its `fwd_sel_b` is 2'b00 in the next cycle, and `st_data_fwd` is high for exactly one cycle, two cycles after decode.
- R10: A store whose rs1 (base) matches a load in execute stalls as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_rs1 | input | REG_AW | First source register of the decode instruction |
| id_rs2 | input | REG_AW | Second source register of the decode instruction |
| id_use_rs1 | input | 1 | Decode instruction reads rs1 |
| id_use_rs2 | input | 1 | Decode instruction reads rs2 |
| id_is_store | input | 1 | Decode instruction is a store (rs2 is store data) |
| ex_rd | input | REG_AW | Destination of the instruction in execute |
| ex_wen | input | 1 | Instruction in execute writes a register |
| ex_is_load | input | 1 | Instruction in execute is a load |
| mem_rd | input | REG_AW | Destination of the instruction in memory |
| mem_wen | input | 1 | Instruction in memory writes a register |
| fwd_sel_a | output | 2 | ALU operand A source: 00 register file, 10 EX/MEM, 01 MEM/WB |
| fwd_sel_b | output | 2 | ALU operand B source, same encoding |
| st_data_fwd | output | 1 | Store in memory stage takes its data from MEM/WB |
| pc_hold | output | 1 | Keep the program counter |
| ifid_hold | output | 1 | Keep the IF/ID register |
| idex_bubble | output | 1 | Zero the control bits entering ID/EX |

## Verification
The stall and the bypass decision can land in the same cycle. One example is an instruction whose rs1 depends on a load in execute while its rs2 depends on an ALU result in the memory stage. In that case the stall must win and both selects must be cleared for the bubble. The bench drives this collision directly. It checks that the hold lines rise, that both selects read 2'b00 on the next cycle, and that no late store flag appears. A store paired with a load on its data register is then run next to a store paired on its base register. This shows that the same match either stalls or defers depending on which operand it hits.

// File: rtl/fwd_pkg.sv
// Shared encodings for the bypass unit.
// Assumes a two-bit select per ALU operand.
package fwd_pkg;
    typedef enum logic [1:0] {
        SEL_RF    = 2'b00,
        SEL_MEMWB = 2'b01,
        SEL_EXMEM = 2'b10
    } fwd_sel_e;
endpackage

// File: rtl/fwd_src_match.sv
// Compares one decode-stage source register against the two in-flight writers.
// Assumes register 0 is hard-wired to zero, so it is never a bypass target.
module fwd_src_match #(
    parameter int REG_AW = 5
) (
    input  logic [REG_AW-1:0] src,
    input  logic              use_src,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_wen,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_wen,
    output logic              hit_ex,
    output logic              hit_mem
);
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    // Raise a hit only for a used source and a real, nonzero destination.
    always_comb begin
        hit_ex  = use_src && ex_wen  && (ex_rd  != ZERO_REG) && (ex_rd  == src);
        hit_mem = use_src && mem_wen && (mem_rd != ZERO_REG) && (mem_rd == src);
    end
endmodule

// File: rtl/load_use_detect.sv
// Finds a load in execute whose result the decode instruction needs too early.
// Assumes store data (rs2 of a store) can be served later in the memory stage.
module load_use_detect (
    input  logic hit_ex_a,
    input  logic hit_ex_b,
    input  logic ex_is_load,
    input  logic id_is_store,
    output logic stall,
    output logic late_store
);
    // Stall on a base/ALU dependence; defer a pure store-data dependence.
    always_comb begin
        stall      = ex_is_load && (hit_ex_a || (hit_ex_b && !id_is_store));
        late_store = ex_is_load && hit_ex_b && id_is_store && !stall;
    end
endmodule

// File: rtl/fwd_sel_reg.sv
// Turns decode-stage hits into registered selects for the execute stage.
// Assumes a stall places a bubble in execute, whose selects are don't-care (cleared).
module fwd_sel_reg
    import fwd_pkg::*;
#(
    parameter int NUM_OPS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stall,
    input  logic               ex_is_load,
    input  logic               late_store,
    input  logic [NUM_OPS-1:0] hit_ex,
    input  logic [NUM_OPS-1:0] hit_mem,
    output logic [1:0]         sel_q [NUM_OPS],
    output logic               st_data_fwd
);
    logic [1:0] sel_d [NUM_OPS];
    logic       late_ex_q;
    logic       late_mem_q;

    // Pick the youngest usable producer; a load result is never taken from EX/MEM.
    always_comb begin
        for (int i = 0; i < NUM_OPS; i++) begin
            if (stall)
                sel_d[i] = SEL_RF;
            else if (hit_ex[i] && !ex_is_load)
                sel_d[i] = SEL_EXMEM;
            else if (hit_ex[i])
                sel_d[i] = SEL_RF;
            else if (hit_mem[i])
                sel_d[i] = SEL_MEMWB;
            else
                sel_d[i] = SEL_RF;
        end
    end

    // Capture the selects for the instruction entering execute.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_OPS; i++) begin
            if (!rst_n) sel_q[i] <= SEL_RF;
            else        sel_q[i] <= sel_d[i];
        end
    end

    // Carry the deferred store-data flag from execute to memory stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            late_ex_q  <= 1'b0;
            late_mem_q <= 1'b0;
        end else begin
            late_ex_q  <= late_store;
            late_mem_q <= late_ex_q;
        end
    end

    assign st_data_fwd = late_mem_q;
endmodule

// File: rtl/fwd_hazard_unit.sv
// Top of the bypass and load-use interlock unit.
// Decides operand sources one stage early and stalls the front end for load-use.
module fwd_hazard_unit #(
    parameter int REG_AW = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_AW-1:0] id_rs1,
    input  logic [REG_AW-1:0] id_rs2,
    input  logic              id_use_rs1,
    input  logic              id_use_rs2,
    input  logic              id_is_store,
    input  logic [REG_AW-1:0] ex_rd,
    input  logic              ex_wen,
    input  logic              ex_is_load,
    input  logic [REG_AW-1:0] mem_rd,
    input  logic              mem_wen,
    output logic [1:0]        fwd_sel_a,
    output logic [1:0]        fwd_sel_b,
    output logic              st_data_fwd,
    output logic              pc_hold,
    output logic              ifid_hold,
    output logic              idex_bubble
);
    localparam int NUM_OPS = 2;

    logic [REG_AW-1:0] src     [NUM_OPS];
    logic [NUM_OPS-1:0] use_src;
    logic [NUM_OPS-1:0] hit_ex;
    logic [NUM_OPS-1:0] hit_mem;
    logic [1:0]        sel_q   [NUM_OPS];
    logic              stall;
    logic              late_store;

    // Gather per-operand source fields.
    always_comb begin
        src[0]  = id_rs1;
        src[1]  = id_rs2;
        use_src = {id_use_rs2, id_use_rs1};
    end

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_match
        fwd_src_match #(.REG_AW(REG_AW)) u_match (
            .src     (src[g]),
            .use_src (use_src[g]),
            .ex_rd   (ex_rd),
            .ex_wen  (ex_wen),
            .mem_rd  (mem_rd),
            .mem_wen (mem_wen),
            .hit_ex  (hit_ex[g]),
            .hit_mem (hit_mem[g])
        );
    end

    load_use_detect u_lud (
        .hit_ex_a    (hit_ex[0]),
        .hit_ex_b    (hit_ex[1]),
        .ex_is_load  (ex_is_load),
        .id_is_store (id_is_store),
        .stall       (stall),
        .late_store  (late_store)
    );

    fwd_sel_reg #(.NUM_OPS(NUM_OPS)) u_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .stall       (stall),
        .ex_is_load  (ex_is_load),
        .late_store  (late_store),
        .hit_ex      (hit_ex),
        .hit_mem     (hit_mem),
        .sel_q       (sel_q),
        .st_data_fwd (st_data_fwd)
    );

    // Drive the front-end controls and the execute-stage selects.
    always_comb begin
        fwd_sel_a   = sel_q[0];
        fwd_sel_b   = sel_q[1];
        pc_hold     = stall;
        ifid_hold   = stall;
        idex_bubble = stall;
    end
endmodule

// File: rtl/fwd_hazard_checker.sv
// Temporal checks on the bypass unit, attached to the top by bind.
// Assumes the same parameter and port names as the top module.
module fwd_hazard_checker #(
    parameter int REG_AW = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [REG_AW-1:0] id_rs1,
    input logic [REG_AW-1:0] id_rs2,
    input logic              id_use_rs1,
    input logic              id_use_rs2,
    input logic              id_is_store,
    input logic [REG_AW-1:0] ex_rd,
    input logic              ex_wen,
    input logic              ex_is_load,
    input logic [REG_AW-1:0] mem_rd,
    input logic              mem_wen,
    input logic [1:0]        fwd_sel_a,
    input logic [1:0]        fwd_sel_b,
    input logic              st_data_fwd,
    input logic              pc_hold,
    input logic              ifid_hold,
    input logic              idex_bubble
);
    p_sel_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_sel_a != 2'b11) && (fwd_sel_b != 2'b11));

    p_fwd_exmem_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (id_use_rs1 && ex_wen && !ex_is_load && ex_rd != '0 && id_rs1 == ex_rd)
        |=> fwd_sel_a == 2'b10);

    p_fwd_memwb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (id_use_rs2 && mem_wen && mem_rd != '0 && id_rs2 == mem_rd
         && !(ex_wen && ex_rd == id_rs2) && !pc_hold)
        |=> fwd_sel_b == 2'b01);

    p_zero_reg_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rs1 == '0) |=> fwd_sel_a == 2'b00);

    p_unused_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !id_use_rs2 |=> fwd_sel_b == 2'b00);

    p_bubble_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pc_hold |=> (fwd_sel_a == 2'b00 && fwd_sel_b == 2'b00));

    p_load_use_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_is_load && ex_wen && ex_rd != '0 && id_use_rs1 && id_rs1 == ex_rd)
        |-> (pc_hold && ifid_hold && idex_bubble));

    p_late_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
        st_data_fwd |-> ($past(id_is_store, 2) && $past(ex_is_load, 2)));
endmodule

bind fwd_hazard_unit fwd_hazard_checker #(.REG_AW(REG_AW)) u_chk (.*);

// File: tb/fwd_hazard_unit_bench.sv
// Directed bench for the bypass and load-use interlock unit.
module fwd_hazard_unit_bench;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] id_rs1, id_rs2, ex_rd, mem_rd;
    logic          id_use_rs1, id_use_rs2, id_is_store;
    logic          ex_wen, ex_is_load, mem_wen;
    logic [1:0]    fwd_sel_a, fwd_sel_b;
    logic          st_data_fwd, pc_hold, ifid_hold, idex_bubble;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    fwd_hazard_unit #(.REG_AW(AW)) u_fwd_hazard_unit (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle();
        id_rs1 = '0; id_rs2 = '0; id_use_rs1 = 0; id_use_rs2 = 0; id_is_store = 0;
        ex_rd = '0; ex_wen = 0; ex_is_load = 0; mem_rd = '0; mem_wen = 0;
    endtask

    // Drive at the falling edge, wait one edge, sample just after it.
    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic t_reset();
        idle();
        id_rs1 = 5'd3; id_use_rs1 = 1; ex_rd = 5'd3; ex_wen = 1;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 sel_a in reset", fwd_sel_a, 0);
        chk("R1 st_data_fwd in reset", st_data_fwd, 0);
        @(negedge clk); idle(); rst_n = 1;
        step();
        chk("R1 sel_a after reset", fwd_sel_a, 0);
        chk("R1 sel_b after reset", fwd_sel_b, 0);
    endtask

    task automatic t_exmem();
        @(negedge clk); idle();
        id_rs1 = 5'd3; id_use_rs1 = 1; id_rs2 = 5'd8; id_use_rs2 = 1;
        ex_rd = 5'd3; ex_wen = 1;
        #1 chk("R2 no stall for ALU producer", pc_hold, 0);
        step();
        chk("R2 sel_a from EX/MEM", fwd_sel_a, 2);
        chk("R2 sel_b untouched", fwd_sel_b, 0);
        @(negedge clk); idle();
        id_rs2 = 5'd12; id_use_rs2 = 1; ex_rd = 5'd12; ex_wen = 1;
        step();
        chk("R2 sel_b from EX/MEM", fwd_sel_b, 2);
    endtask

    task automatic t_memwb();
        @(negedge clk); idle();
        id_rs2 = 5'd7; id_use_rs2 = 1; mem_rd = 5'd7; mem_wen = 1;
        ex_rd = 5'd9; ex_wen = 1;
        step();
        chk("R3 sel_b from MEM/WB", fwd_sel_b, 1);
        chk("R3 sel_a idle", fwd_sel_a, 0);
    endtask

    task automatic t_priority();
        @(negedge clk); idle();
        id_rs1 = 5'd4; id_use_rs1 = 1; ex_rd = 5'd4; ex_wen = 1; mem_rd = 5'd4; mem_wen = 1;
        step();
        chk("R4 younger producer wins", fwd_sel_a, 2);
    endtask

    task automatic t_r0();
        @(negedge clk); idle();
        id_use_rs1 = 1; id_use_rs2 = 1; ex_wen = 1; mem_wen = 1;
        step();
        chk("R5 r0 never forwarded a", fwd_sel_a, 0);
        chk("R5 r0 never forwarded b", fwd_sel_b, 0);
        @(negedge clk); idle();
        id_rs1 = 5'd6; id_use_rs1 = 1; ex_rd = 5'd6; ex_wen = 0; ex_is_load = 1;
        mem_rd = 5'd6; mem_wen = 0;
        #1 chk("R5 non-writing load no stall", pc_hold, 0);
        step();
        chk("R5 non-writer no forward", fwd_sel_a, 0);
        @(negedge clk); idle();
        id_use_rs1 = 1; ex_wen = 1; ex_is_load = 1;
        #1 chk("R5 load to r0 no stall", pc_hold, 0);
        step();
    endtask

    task automatic t_unused();
        @(negedge clk); idle();
        id_rs1 = 5'd1; id_use_rs1 = 1; id_rs2 = 5'd5; id_use_rs2 = 0;
        ex_rd = 5'd5; ex_wen = 1; ex_is_load = 1;
        #1 chk("R6 unused rs2 no stall", pc_hold, 0);
        step();
        chk("R6 unused rs2 no select", fwd_sel_b, 0);
    endtask

    task automatic t_loaduse();
        @(negedge clk); idle();
        id_rs1 = 5'd6; id_use_rs1 = 1; ex_rd = 5'd6; ex_wen = 1; ex_is_load = 1;
        #1;
        chk("R7 pc_hold", pc_hold, 1);
        chk("R7 ifid_hold", ifid_hold, 1);
        chk("R7 idex_bubble", idex_bubble, 1);
        step();
        chk("R7 bubble select a", fwd_sel_a, 0);
        @(negedge clk); idle();
        id_rs1 = 5'd6; id_use_rs1 = 1; mem_rd = 5'd6; mem_wen = 1;
        #1 chk("R8 stall lasts one cycle", pc_hold, 0);
        step();
        chk("R8 held instruction takes MEM/WB", fwd_sel_a, 1);
    endtask

    task automatic t_store();
        @(negedge clk); idle();
        id_is_store = 1; id_rs1 = 5'd2; id_use_rs1 = 1; id_rs2 = 5'd9; id_use_rs2 = 1;
        ex_rd = 5'd9; ex_wen = 1; ex_is_load = 1;
        #1 chk("R9 store data no stall", pc_hold, 0);
        step();
        chk("R9 sel_b stays register file", fwd_sel_b, 0);
        chk("R9 flag not yet", st_data_fwd, 0);
        @(negedge clk); idle();
        step();
        chk("R9 late store flag", st_data_fwd, 1);
        @(negedge clk); idle();
        step();
        chk("R9 flag one cycle", st_data_fwd, 0);
        @(negedge clk); idle();
        id_is_store = 1; id_rs1 = 5'd9; id_use_rs1 = 1; id_rs2 = 5'd2; id_use_rs2 = 1;
        ex_rd = 5'd9; ex_wen = 1; ex_is_load = 1;
        #1 chk("R10 store base stalls", pc_hold, 1);
        step();
    endtask

    task automatic t_collide();
        @(negedge clk); idle();
        id_is_store = 1; id_rs1 = 5'd10; id_use_rs1 = 1; id_rs2 = 5'd11; id_use_rs2 = 1;
        ex_rd = 5'd10; ex_wen = 1; ex_is_load = 1; mem_rd = 5'd11; mem_wen = 1;
        #1 chk("R7 collision stalls", pc_hold, 1);
        step();
        chk("R7 collision sel_a cleared", fwd_sel_a, 0);
        chk("R7 collision sel_b cleared", fwd_sel_b, 0);
        @(negedge clk); idle();
        step();
        chk("R9 no late flag on stall", st_data_fwd, 0);
    endtask

    initial begin
        #(8 * 20000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_exmem();
        t_memwb();
        t_priority();
        t_r0();
        t_unused();
        t_loaduse();
        t_store();
        t_collide();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule